// File: doc/BRIEF.md
# SPI Communication Watchdog

This block supervises the serial control link of a driver chip. A free-running 25-bit counter advances on every system clock and is zeroed each time the link delivers a valid frame. Software selects the timeout by naming the counter bit that acts as the expiry tap. With a clock of about 10 MHz, the default tap of bit 24 gives a silence window of roughly 1.67 s.

When the tapped bit becomes set, the block declares a communication error. It also advances a small saturating count of timeout events. It then raises a request for the chip to fall back to stand-alone (limp-home) operation. The request stays up until reset. Deciding what the chip does in that mode belongs to the surrounding logic. The enable input lets software park the watchdog; while it is low the counter rests at zero and nothing expires.

Top module: `spi_comm_watchdog`

## Requirements
- R1: After synchronous reset, `comm_err`, `timeout_events` and `limp_req` are all 0 and the counter restarts from zero.
- R2: With the watchdog enabled and no frame, the counter rises by one per clock. An expiry occurs in the cycle in which counter bit `tap_sel` reads 1. The first `comm_err` is therefore visible 2^tap + 1 clock edges after the edge that sampled the last frame.
- R3: A `tap_sel` value above 24 behaves exactly as 24, so no expiry occurs within 2^24 cycles.
- R4: A cycle with `frame_ok` high zeroes the counter. When it coincides with an expiry, the frame wins and no expiry is recorded.
- R5: An expiry sets `comm_err` at the next edge. A `frame_ok` pulse clears it at the next edge, whether or not the watchdog is enabled.
- R6: Each expiry adds one to the 2-bit `timeout_events`, which holds at 3 once reached and is cleared only by reset.
- R7: `limp_req` goes high on the first expiry and stays high until reset.
- R8: While `wd_en` is 0 the counter is held at zero and no expiry occurs. On re-enable, counting starts from zero.
- R9: After an expiry the counter restarts from zero, so a silent link expires every 2^tap + 1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wd_en | input | 1 | Watchdog enable |
| tap_sel | input | 5 | Index of the counter bit used as expiry tap |
| frame_ok | input | 1 | One-cycle pulse per valid serial frame |
| comm_err | output | 1 | Communication error flag |
| timeout_events | output | 2 | Saturating count of expiries |
| limp_req | output | 1 | Request to enter limp-home operation |

## Verification
The hardest case to reach from the ports is a frame arriving in the very cycle in which the tap bit has just become set. With tap 0, a frame followed by one idle cycle lands the next frame exactly on the expiring count. This shows whether the frame overrides the expiry. Saturation of the event count needs several back-to-back expiries, which a small tap makes cheap. The clamp of oversized taps is shown by running thousands of cycles with no expiry. Any mistaken clamp to a small bit would have fired well within that window.

// File: rtl/spiwd_pkg.sv
package spiwd_pkg;

    localparam int unsigned WD_CNT_W = 25;
    localparam int unsigned WD_EVT_W = 2;

    typedef enum logic {
        WD_NORMAL = 1'b0,
        WD_LIMP   = 1'b1
    } wd_mode_e;

    typedef struct packed {
        logic     err;
        wd_mode_e mode;
    } wd_status_t;

    // Limit a requested tap index to the highest counter bit.
    function automatic int unsigned wd_clamp(int unsigned req, int unsigned top_bit);
        return (req > top_bit) ? top_bit : req;
    endfunction

endpackage

// File: rtl/spiwd_tap_sel.sv
module spiwd_tap_sel #(
    parameter int CNT_W = spiwd_pkg::WD_CNT_W,
    parameter int TAP_W = $clog2(CNT_W)
) (
    input  logic [TAP_W-1:0] tap_sel,
    output logic [CNT_W-1:0] tap_mask
);
    localparam int unsigned TOP_BIT = CNT_W - 1;

    logic [TAP_W-1:0] tap_eff;

    always_comb begin
        tap_eff = TAP_W'(spiwd_pkg::wd_clamp(int'(tap_sel), TOP_BIT));
    end

    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign tap_mask[i] = (tap_eff == TAP_W'(i));
    end

endmodule

// File: rtl/spiwd_timebase.sv
module spiwd_timebase #(
    parameter int CNT_W = spiwd_pkg::WD_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wd_en,
    input  logic             frame_ok,
    input  logic [CNT_W-1:0] tap_mask,
    output logic [CNT_W-1:0] wd_cnt,
    output logic             expire
);
    logic tap_hit;

    assign tap_hit = |(wd_cnt & tap_mask);
    assign expire  = wd_en & tap_hit & ~frame_ok;

    always_ff @(posedge clk) begin
        if (rst || !wd_en || frame_ok || expire) begin
            wd_cnt <= '0;
        end else begin
            wd_cnt <= wd_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spiwd_escalate.sv
module spiwd_escalate #(
    parameter int EVT_W = spiwd_pkg::WD_EVT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_ok,
    input  logic                   expire,
    output spiwd_pkg::wd_status_t  status,
    output logic [EVT_W-1:0]       events
);
    import spiwd_pkg::*;

    localparam logic [EVT_W-1:0] EVT_MAX = {EVT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            status.err  <= 1'b0;
            status.mode <= WD_NORMAL;
            events      <= '0;
        end else begin
            if (frame_ok) begin
                status.err <= 1'b0;
            end
            if (expire) begin
                status.err  <= 1'b1;
                status.mode <= WD_LIMP;
                if (events != EVT_MAX) begin
                    events <= events + EVT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/spi_comm_watchdog.sv
module spi_comm_watchdog #(
    parameter int CNT_W = spiwd_pkg::WD_CNT_W,
    parameter int TAP_W = $clog2(CNT_W),
    parameter int EVT_W = spiwd_pkg::WD_EVT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wd_en,
    input  logic [TAP_W-1:0] tap_sel,
    input  logic             frame_ok,
    output logic             comm_err,
    output logic [EVT_W-1:0] timeout_events,
    output logic             limp_req
);
    import spiwd_pkg::*;

    logic [CNT_W-1:0] tap_mask;
    logic [CNT_W-1:0] wd_cnt;
    logic             expire;
    wd_status_t       status;

    spiwd_tap_sel #(.CNT_W(CNT_W), .TAP_W(TAP_W)) u_tap (
        .tap_sel  (tap_sel),
        .tap_mask (tap_mask)
    );

    spiwd_timebase #(.CNT_W(CNT_W)) u_base (
        .clk      (clk),
        .rst      (rst),
        .wd_en    (wd_en),
        .frame_ok (frame_ok),
        .tap_mask (tap_mask),
        .wd_cnt   (wd_cnt),
        .expire   (expire)
    );

    spiwd_escalate #(.EVT_W(EVT_W)) u_esc (
        .clk      (clk),
        .rst      (rst),
        .frame_ok (frame_ok),
        .expire   (expire),
        .status   (status),
        .events   (timeout_events)
    );

    assign comm_err = status.err;
    assign limp_req = (status.mode == WD_LIMP);

endmodule

// File: rtl/spiwd_checker.sv
module spiwd_checker #(
    parameter int CNT_W = spiwd_pkg::WD_CNT_W,
    parameter int EVT_W = spiwd_pkg::WD_EVT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             wd_en,
    input logic             frame_ok,
    input logic             expire,
    input logic [CNT_W-1:0] wd_cnt,
    input logic [CNT_W-1:0] tap_mask,
    input logic             comm_err,
    input logic [EVT_W-1:0] timeout_events,
    input logic             limp_req
);
    localparam logic [EVT_W-1:0] EVT_MAX = {EVT_W{1'b1}};

    assert_tap_single_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_mask) == 1);

    assert_frame_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        frame_ok |=> (wd_cnt == '0) && !comm_err);

    assert_err_on_expiry_R5: assert property (@(posedge clk) disable iff (rst)
        expire |=> comm_err);

    assert_evt_step_R6: assert property (@(posedge clk) disable iff (rst)
        (timeout_events != $past(timeout_events)) |->
            (timeout_events == EVT_W'($past(timeout_events) + 1'b1)));

    assert_evt_saturate_R6: assert property (@(posedge clk) disable iff (rst)
        (timeout_events == EVT_MAX) |=> (timeout_events == EVT_MAX));

    assert_limp_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        limp_req |=> limp_req);

    assert_idle_frozen_R8: assert property (@(posedge clk) disable iff (rst)
        !wd_en |=> $stable(timeout_events) && $stable(limp_req) && (wd_cnt == '0));

    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        expire |=> (wd_cnt == '0));

endmodule

bind spi_comm_watchdog spiwd_checker #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wd_en          (wd_en),
    .frame_ok       (frame_ok),
    .expire         (expire),
    .wd_cnt         (wd_cnt),
    .tap_mask       (tap_mask),
    .comm_err       (comm_err),
    .timeout_events (timeout_events),
    .limp_req       (limp_req)
);

// File: tb/spi_comm_watchdog_tb.sv
module spi_comm_watchdog_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wd_en = 1'b0;
    logic [4:0] tap_sel = 5'd0;
    logic       frame_ok = 1'b0;
    logic       comm_err;
    logic [1:0] timeout_events;
    logic       limp_req;

    int    checks = 0;
    int    errors = 0;
    string phase = "R1";

    // reference model state
    longint m_cnt = 0;
    int     m_evt = 0;
    bit     m_err = 0;
    bit     m_limp = 0;

    spi_comm_watchdog u_dut (
        .clk            (clk),
        .rst            (rst),
        .wd_en          (wd_en),
        .tap_sel        (tap_sel),
        .frame_ok       (frame_ok),
        .comm_err       (comm_err),
        .timeout_events (timeout_events),
        .limp_req       (limp_req)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        int eff;
        bit fire;
        if (rst) begin
            m_cnt = 0; m_evt = 0; m_err = 0; m_limp = 0;
        end else begin
            eff  = (tap_sel > 5'd24) ? 24 : int'(tap_sel);
            fire = wd_en && !frame_ok && (((m_cnt >> eff) & 1) == 1);
            if (frame_ok) m_err = 0;
            if (fire) begin
                m_err  = 1;
                m_limp = 1;
                if (m_evt < 3) m_evt++;
            end
            if (!wd_en || frame_ok || fire) m_cnt = 0;
            else m_cnt++;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // compare against the model on every clock, away from the active edge
    always @(negedge clk) begin
        chk({phase, " model comm_err"}, int'(comm_err), int'(m_err));
        chk({phase, " model timeout_events"}, int'(timeout_events), m_evt);
        chk({phase, " model limp_req"}, int'(limp_req), int'(m_limp));
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_frame();
        frame_ok = 1'b1;
        tick(1);
        frame_ok = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        tick(3);
        phase = "R1";
        chk("R1 reset comm_err", int'(comm_err), 0);
        chk("R1 reset events", int'(timeout_events), 0);
        chk("R1 reset limp", int'(limp_req), 0);

        rst = 1'b0; wd_en = 1'b1; tap_sel = 5'd2;
        phase = "R2";
        pulse_frame();
        tick(4);
        chk("R2 no early expiry", int'(comm_err), 0);
        tick(1);
        chk("R2 expiry after 2^tap+1", int'(comm_err), 1);
        chk("R6 first event", int'(timeout_events), 1);
        chk("R7 limp raised", int'(limp_req), 1);

        phase = "R9";
        tick(5);
        chk("R9 second expiry", int'(timeout_events), 2);
        tick(4);
        chk("R9 spacing", int'(timeout_events), 2);
        tick(1);
        chk("R6 third event", int'(timeout_events), 3);
        phase = "R6";
        tick(20);
        chk("R6 saturates at 3", int'(timeout_events), 3);

        phase = "R5";
        pulse_frame();
        chk("R5 frame clears err", int'(comm_err), 0);
        chk("R7 limp held", int'(limp_req), 1);

        phase = "R4";
        for (int i = 0; i < 30; i++) begin
            pulse_frame();
            tick(3);
        end
        chk("R4 fed link stays clean", int'(comm_err), 0);

        tap_sel = 5'd0;
        pulse_frame();
        tick(1);
        pulse_frame();
        chk("R4 frame beats coincident expiry", int'(comm_err), 0);
        tick(1);
        chk("R4 counting after frame", int'(comm_err), 0);
        tick(1);
        chk("R2 tap0 expiry", int'(comm_err), 1);

        phase = "R8";
        wd_en = 1'b0;
        pulse_frame();
        tick(200);
        chk("R8 disabled no expiry", int'(comm_err), 0);
        chk("R8 events frozen", int'(timeout_events), 3);
        wd_en = 1'b1;
        tick(1);
        chk("R8 restart from zero", int'(comm_err), 0);
        tick(1);
        chk("R8 expiry after re-enable", int'(comm_err), 1);

        phase = "R1";
        rst = 1'b1;
        tick(2);
        chk("R1 reset clears limp", int'(limp_req), 0);
        chk("R1 reset clears events", int'(timeout_events), 0);
        rst = 1'b0;

        phase = "R3";
        tap_sel = 5'd31;
        pulse_frame();
        tick(3000);
        chk("R3 tap 31 clamped", int'(comm_err), 0);
        tap_sel = 5'd25;
        tick(2000);
        chk("R3 tap 25 clamped", int'(comm_err), 0);
        tap_sel = 5'd24;
        tick(1000);
        chk("R3 tap 24 quiet", int'(comm_err), 0);

        phase = "R2";
        tap_sel = 5'd10;
        pulse_frame();
        tick(1024);
        chk("R2 tap10 before expiry", int'(comm_err), 0);
        tick(1);
        chk("R2 tap10 expiry", int'(comm_err), 1);
        chk("R6 event after reset", int'(timeout_events), 1);

        tap_sel = 5'd3;
        pulse_frame();
        tick(5);
        tap_sel = 5'd1;
        tick(12);
        tick(2);
        finish_run();
    end

endmodule